// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Core

A compact non-pipelined 16-bit processor. Each instruction passes through five fixed states in order: fetch, decode, execute, memory and write-back. A state-only sequencer drives the datapath from these states. The datapath has a four-entry register file, an ALU, a sign-extension path for the 8-bit immediate, and program counter logic that handles jumps and equality branches. A 16-word instruction memory and a 16-word data memory are internal arrays. A load port fills both of them while the core is held in reset.

A 16-bit external input stands in for a bank of switches. One instruction copies this input into a register. For debug, three outputs show the current program counter, the instruction register and the latched ALU result. A pulse marks the write-back cycle of every instruction. This lets a test program expose register contents by routing them through the ALU.

Top module: `mini16_core`

## Requirements
- R1: Instruction fields are opcode = bits 15:12, first source = bits 11:10 and second source/I-type destination = bits 9:8. In R-type instructions the destination register is bits 1:0 of the low byte, and bits 7:2 are ignored. In I-type instructions bits 7:0 are an 8-bit immediate.
- R2: The R-type opcodes write the following results to the destination register:
  - 0: Rs+Rt
  - 1: Rs-Rt
  - 2: Rs&Rt
  - 3: Rs|Rt
  - 4: Rs^Rt
  - 5: ~Rs
- R3: Opcode 6 writes Rs plus the sign-extended immediate into Rt.
- R4: Opcode 7 writes the value of ext_data_i into Rt.
- R5: Opcodes 8 (load) and 9 (store) use Rs plus the sign-extended immediate as the address, and only its low 4 bits select the data word. A load writes that word into Rt. A store writes Rt into that word.
- R6: Every instruction takes exactly five cycles. retire_o is high for the last cycle of each instruction. alu_o then shows the ALU result of that instruction: the address for opcodes 8 and 9, and Rs-Rt for opcode A.
- R7: Apart from taken control transfers, the PC advances by one (modulo 16) at the end of each instruction and holds in every other cycle.
- R8: Opcode B loads the PC with immediate bits 3:0.
- R9: Opcode A compares Rs with Rt. When they are equal, the PC becomes PC+1 plus the sign-extended immediate, modulo 16. When they differ, the PC becomes PC+1.
- R10: A register written by one instruction holds the new value when the very next instruction reads it.
- R11: Opcodes C through F change neither registers nor data memory. The PC then advances by one.
- R12: While rst_ni is low, pc_o, instr_o and alu_o read zero, retire_o is low and every register is cleared. The first instruction after reset is fetched from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_data_i | input | 16 | External data operand for opcode 7 |
| ld_we_i | input | 1 | Memory load port write strobe |
| ld_dmem_i | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | 4 | Load port word address |
| ld_data_i | input | 16 | Load port write data |
| pc_o | output | 4 | Current program counter |
| instr_o | output | 16 | Instruction register |
| alu_o | output | 16 | Latched ALU result |
| retire_o | output | 1 | High in the write-back cycle of each instruction |

## Verification
The hardest situations to reach from the ports are branch targets that wrap past address 15 and a register being read right after a falling-edge write. Registers and data memory have no direct outputs. The stimulus therefore uses preloaded programs with back-to-back dependent instructions, a taken branch whose offset carries past the top of memory, and a store followed by a load at an address that differs from the stored one only in its upper bits. Each value is then moved through an R-type instruction so that it appears on alu_o. A bench-side instruction model predicts every retired instruction: its PC, its instruction word and its ALU value.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h3;
  localparam logic [3:0] OP_XOR  = 4'h4;
  localparam logic [3:0] OP_NOT  = 4'h5;
  localparam logic [3:0] OP_ADDI = 4'h6;
  localparam logic [3:0] OP_LDX  = 4'h7;
  localparam logic [3:0] OP_LW   = 4'h8;
  localparam logic [3:0] OP_SW   = 4'h9;
  localparam logic [3:0] OP_BEQ  = 4'hA;
  localparam logic [3:0] OP_JMP  = 4'hB;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2,
    ALU_OR  = 4'd3, ALU_XOR = 4'd4, ALU_NOT = 4'd5
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0, ST_DECODE = 3'd1, ST_EXEC = 3'd2,
    ST_MEM = 3'd3, ST_WB = 3'd4
  } state_e;

  typedef enum logic [1:0] {WD_ALU = 2'd0, WD_MEM = 2'd1, WD_EXT = 2'd2} wd_sel_e;

  typedef struct packed {
    logic    pc_inc;
    logic    pc_ld;
    logic    im_read;
    logic    rf_read;
    logic    alu_en;
    logic    dm_read;
    logic    dm_write;
    logic    reg_we;
    logic    b_imm;
    logic    dst_rt;
    wd_sel_e wd_sel;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile #(
  parameter int unsigned NREG = 4,
  parameter int unsigned W    = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  a_o,
  output logic [W-1:0]  b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  // writes land mid-cycle so the following rising-edge read sees them
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
    end else if (rd_en_i) begin
      a_o <= regs_q[ra_i];
      b_o <= regs_q[rb_i];
    end
  end
endmodule

// File: rtl/mini16_ctrl.sv
module mini16_ctrl
  import mini16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] opcode_i,
  input  logic       zero_i,
  output state_e     state_o,
  output ctrl_t      ctrl_o
);
  state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_MEM;
      ST_MEM:    state_d = ST_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  logic writes_reg;
  assign writes_reg = (opcode_i <= OP_LW);

  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OP_SUB, OP_BEQ: ctrl_o.alu_op = ALU_SUB;
      OP_AND:         ctrl_o.alu_op = ALU_AND;
      OP_OR:          ctrl_o.alu_op = ALU_OR;
      OP_XOR:         ctrl_o.alu_op = ALU_XOR;
      OP_NOT:         ctrl_o.alu_op = ALU_NOT;
      default:        ctrl_o.alu_op = ALU_ADD;
    endcase
    ctrl_o.b_imm  = (opcode_i == OP_ADDI) || (opcode_i == OP_LW) || (opcode_i == OP_SW);
    ctrl_o.dst_rt = (opcode_i == OP_ADDI) || (opcode_i == OP_LDX) || (opcode_i == OP_LW);
    ctrl_o.wd_sel = (opcode_i == OP_LW)  ? WD_MEM :
                    (opcode_i == OP_LDX) ? WD_EXT : WD_ALU;
    unique case (state_q)
      ST_FETCH:  ctrl_o.im_read = 1'b1;
      ST_DECODE: ctrl_o.rf_read = 1'b1;
      ST_EXEC:   ctrl_o.alu_en  = 1'b1;
      ST_MEM: begin
        ctrl_o.dm_read  = (opcode_i == OP_LW);
        ctrl_o.dm_write = (opcode_i == OP_SW);
      end
      default: begin
        ctrl_o.reg_we = writes_reg;
        ctrl_o.pc_ld  = (opcode_i == OP_JMP) || ((opcode_i == OP_BEQ) && zero_i);
        ctrl_o.pc_inc = !ctrl_o.pc_ld;
      end
    endcase
  end

  assign state_o = state_q;

  AST_EXEC_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC |=> state_q == ST_MEM); // R6
  AST_WB_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WB |=> state_q == ST_FETCH); // R6
  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i >= 4'hC |-> !(ctrl_o.reg_we || ctrl_o.dm_write)); // R11
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned NREG   = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 2 ** ADDR_W,
  localparam int unsigned RAW   = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      ext_data_i,
  input  logic              ld_we_i,
  input  logic              ld_dmem_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [W-1:0]      ld_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [W-1:0]      instr_o,
  output logic [W-1:0]      alu_o,
  output logic              retire_o
);
  logic [W-1:0]      imem [DEPTH];
  logic [W-1:0]      dmem [DEPTH];
  logic [ADDR_W-1:0] pc_q;
  logic [W-1:0]      ir_q, alu_q, mdr_q;
  logic              zero_q;
  state_e            state;
  ctrl_t             ctrl;

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem[ld_addr_i] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i)  dmem[ld_addr_i] <= ld_data_i;
    else if (ctrl.dm_write)    dmem[alu_q[ADDR_W-1:0]] <= rb_q;
  end

  mini16_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opcode_i(ir_q[15:12]),
    .zero_i  (zero_q),
    .state_o (state),
    .ctrl_o  (ctrl)
  );

  // decode fields
  logic [RAW-1:0] rs, rt, rd, wa;
  logic [W-1:0]   sext;
  assign rs   = ir_q[10 +: RAW];
  assign rt   = ir_q[8 +: RAW];
  assign rd   = ir_q[0 +: RAW];
  assign sext = {{(W-8){ir_q[7]}}, ir_q[7:0]};
  assign wa   = ctrl.dst_rt ? rt : rd;

  logic [W-1:0] ra_q, rb_q, wd;
  always_comb begin
    unique case (ctrl.wd_sel)
      WD_MEM:  wd = mdr_q;
      WD_EXT:  wd = ext_data_i;
      default: wd = alu_q;
    endcase
  end

  mini16_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(ctrl.rf_read),
    .ra_i   (rs),
    .rb_i   (rt),
    .a_o    (ra_q),
    .b_o    (rb_q),
    .we_i   (ctrl.reg_we),
    .wa_i   (wa),
    .wd_i   (wd)
  );

  logic [W-1:0] alu_b, alu_y;
  logic         alu_z;
  assign alu_b = ctrl.b_imm ? sext : rb_q;

  mini16_alu #(.W(W)) u_alu (
    .a_i   (ra_q),
    .b_i   (alu_b),
    .op_i  (ctrl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_z)
  );

  logic [ADDR_W-1:0] pc_inc, pc_tgt;
  assign pc_inc = pc_q + 1'b1;
  assign pc_tgt = (ir_q[15:12] == OP_JMP) ? ir_q[ADDR_W-1:0] : pc_inc + sext[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      alu_q  <= '0;
      zero_q <= 1'b0;
      mdr_q  <= '0;
    end else begin
      if (ctrl.im_read) ir_q <= imem[pc_q];
      if (ctrl.alu_en) begin
        alu_q  <= alu_y;
        zero_q <= alu_z;
      end
      if (ctrl.dm_read) mdr_q <= dmem[alu_q[ADDR_W-1:0]];
      if (ctrl.pc_ld)       pc_q <= pc_tgt;
      else if (ctrl.pc_inc) pc_q <= pc_inc;
    end
  end

  assign pc_o     = pc_q;
  assign instr_o  = ir_q;
  assign alu_o    = alu_q;
  assign retire_o = (state == ST_WB);

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != ST_WB |=> $stable(pc_q)); // R7
  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WB && !ctrl.pc_ld) |=> pc_q == $past(pc_q) + 1'b1); // R7
  AST_JMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WB && ir_q[15:12] == OP_JMP) |=> pc_q == $past(ir_q[ADDR_W-1:0])); // R8
  AST_BEQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WB && ir_q[15:12] == OP_BEQ && !zero_q) |=> pc_q == $past(pc_q) + 1'b1); // R9
  AST_RF_WE_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.reg_we |-> retire_o && $stable(alu_q)); // R10
endmodule

// File: tb/tb_mini16_core.sv
module tb_mini16_core;
  localparam time CLK_PERIOD = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ext_data_i = '0;
  logic        ld_we_i = 1'b0, ld_dmem_i = 1'b0;
  logic [3:0]  ld_addr_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [3:0]  pc_o;
  logic [15:0] instr_o, alu_o;
  logic        retire_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mini16_core dut (.*);

  typedef struct {
    logic [3:0]  pc;
    logic [15:0] ir;
    logic [15:0] alu;
    bit          chk_alu;
    string       req;
  } item_t;

  item_t       exp_q[$];
  int          n_cmp = 0, n_bad = 0;
  int          cyc = 0;
  logic [15:0] im_img [16];
  logic [15:0] dm_img [16];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per retired instruction
  always @(negedge clk_i) begin
    if (!rst_ni) cyc = 1;
    else begin
      cyc++;
      if (retire_o && exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        check(cyc == 5, "R6", "cycles per instruction", 16'(cyc), 16'd5);
        check(pc_o == e.pc, "R7", "retired pc", {12'd0, pc_o}, {12'd0, e.pc});
        check(instr_o == e.ir, e.req, "instruction word", instr_o, e.ir);
        if (e.chk_alu) check(alu_o == e.alu, e.req, "alu result", alu_o, e.alu);
        cyc = 0;
      end else if (retire_o) cyc = 0;
    end
  end

  // driver: reset, preload, then push the model's view of n instructions
  task automatic run_prog(input logic [15:0] ext, input int n);
    logic [15:0] r [4];
    logic [15:0] dm [16];
    logic [3:0]  pc;
    @(negedge clk_i); #2ns;
    rst_ni = 1'b0;
    ext_data_i = ext;
    for (int i = 0; i < 32; i++) begin
      ld_we_i = 1'b1; ld_dmem_i = (i >= 16); ld_addr_i = 4'(i);
      ld_data_i = (i >= 16) ? dm_img[i-16] : im_img[i];
      @(negedge clk_i); #2ns;
    end
    ld_we_i = 1'b0;
    // R12: reset state at the ports
    check(pc_o == 4'd0, "R12", "pc in reset", {12'd0, pc_o}, 16'd0);
    check(retire_o == 1'b0, "R12", "retire in reset", {15'd0, retire_o}, 16'd0);
    check(instr_o == 16'd0 && alu_o == 16'd0, "R12", "ir/alu in reset", instr_o | alu_o, 16'd0);
    for (int i = 0; i < 4; i++) r[i] = '0;
    for (int i = 0; i < 16; i++) dm[i] = dm_img[i];
    pc = '0;
    for (int k = 0; k < n; k++) begin
      item_t it;
      logic [15:0] ir, a, b, y, se;
      logic [3:0]  op, npc;
      logic [1:0]  rs, rt, rd;
      ir = im_img[pc];
      op = ir[15:12]; rs = ir[11:10]; rt = ir[9:8]; rd = ir[1:0]; // R1
      se = {{8{ir[7]}}, ir[7:0]};
      a = r[rs]; b = r[rt]; y = '0; npc = pc + 4'd1;
      it.chk_alu = 1'b1; it.req = "R2";
      case (op)
        4'h0: begin y = a + b;  r[rd] = y; end
        4'h1: begin y = a - b;  r[rd] = y; end
        4'h2: begin y = a & b;  r[rd] = y; end
        4'h3: begin y = a | b;  r[rd] = y; end
        4'h4: begin y = a ^ b;  r[rd] = y; end
        4'h5: begin y = ~a;     r[rd] = y; end
        4'h6: begin y = a + se; r[rt] = y; it.req = "R3"; end
        4'h7: begin r[rt] = ext; it.chk_alu = 1'b0; it.req = "R4"; end
        4'h8: begin y = a + se; r[rt] = dm[y[3:0]]; it.req = "R5"; end
        4'h9: begin y = a + se; dm[y[3:0]] = b; it.req = "R5"; end
        4'hA: begin y = a - b; it.req = "R9"; if (y == 16'd0) npc = pc + 4'd1 + se[3:0]; end
        4'hB: begin npc = ir[3:0]; it.chk_alu = 1'b0; it.req = "R8"; end
        default: begin it.chk_alu = 1'b0; it.req = "R11"; end
      endcase
      it.pc = pc; it.ir = ir; it.alu = y;
      exp_q.push_back(it);
      pc = npc;
    end
    rst_ni = 1'b1;
    wait (exp_q.size() == 0);
  endtask

  initial begin
    // P1: ALU ops, dependent chain (R10), rd high bits ignored (R1), store/load
    for (int i = 0; i < 16; i++) begin im_img[i] = 16'h0000; dm_img[i] = 16'h0000; end
    im_img[0]  = 16'h7100; im_img[1]  = 16'h62FD; im_img[2]  = 16'h06F3;
    im_img[3]  = 16'h1603; im_img[4]  = 16'h2603; im_img[5]  = 16'h3603;
    im_img[6]  = 16'h4603; im_img[7]  = 16'h5403; im_img[8]  = 16'h9105;
    im_img[9]  = 16'h8B08; im_img[10] = 16'h0C00; im_img[11] = 16'hC000;
    im_img[12] = 16'hB000;
    run_prog(16'h1234, 30);

    // P2: counting loop, taken/untaken BEQ, JMP, branch target wrapping past 15 (R9)
    for (int i = 0; i < 16; i++) begin im_img[i] = 16'h0000; dm_img[i] = 16'h0000; end
    im_img[0] = 16'h7100; im_img[1] = 16'h6201; im_img[2] = 16'h0E03;
    im_img[3] = 16'hAD02; im_img[4] = 16'hB002; im_img[5] = 16'hF000;
    im_img[6] = 16'hA00A;
    run_prog(16'h0005, 40);

    // P3: preloaded data, negative offset, unused opcodes (R11), pc wrap (R7)
    for (int i = 0; i < 16; i++) begin im_img[i] = 16'h0000; dm_img[i] = 16'h0000; end
    dm_img[15] = 16'hBEEF; dm_img[6] = 16'h0042;
    im_img[0] = 16'h81FF; im_img[1] = 16'hD1FF; im_img[2] = 16'hE2AA;
    im_img[3] = 16'h0402; im_img[4] = 16'h9113; im_img[5] = 16'h8303;
    im_img[6] = 16'h3C00; im_img[7] = 16'h8207; im_img[8] = 16'h0802;
    run_prog(16'hFFFF, 30);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule